// File: doc/BRIEF.md
# YCbCr 4:2:2 Pixel Port Formatter

This block takes a 4:2:2 video sample stream at the full sample rate (nominally 27 MHz). The stream is one byte per clock in the order Cb, Y, Cr, Y. The block repacks it onto a 16-bit output data bus in one of two layouts. The narrow layout carries every sample on one byte lane at the full rate and leaves the other lane undriven. The wide layout puts luma on the upper lane and chroma on the lower lane, so each word lasts two clocks (half rate, nominally 13.5 MHz).

Four input samples are gathered into a pixel pair, and each completed pair is shown in four output slots. The chroma order within a pair can be reversed. The block also produces a half-rate clock from a divide-by-two register that is phase-locked to the output slots. A select field chooses whether the full-rate or the half-rate clock appears on the primary clock pin, and a polarity bit inverts both clock outputs.

A small write-only configuration port holds the format, swap, clock-select and polarity fields. Output lane enables stand in for three-state drivers.

Top module: `pixel_port_fmt`

## Requirements
- R1: After reset the format is narrow (code 4'b0011), swap is off, the primary clock pin carries the full-rate clock and polarity is normal. Until the first pair completes, p_oe reads 16'hFF00 and p_data reads zero.
- R2: Format code 4'b0011 sends one sample per clock on p_data[15:8], with p_oe[15:8] high. Slots 0 to 3 carry the leading chroma, the even luma, the trailing chroma and the odd luma. p_data[7:0] is zero and p_oe[7:0] is low.
- R3: Format code 4'b0010 drives all 16 lanes, with luma on p_data[15:8] and chroma on p_data[7:0]. Slots 0 and 1 hold {even Y, leading chroma}. Slots 2 and 3 hold {odd Y, trailing chroma}.
- R4: Any other format code, including the reserved codes 4'b0110 to 4'b1111, leaves the bus undriven: p_oe and p_data are all zero.
- R5: With swap 0 the leading chroma is Cb, the first sample of the pair, and the trailing chroma is Cr. With swap 1 the two change places.
- R6: A sample taken with in_sol and in_act both high is the Cb of a new pair, and any partly collected pair is dropped. in_act low also returns the phase to Cb.
- R7: Format and swap are sampled only on the clock that completes a pair. All four slots of that pair use those values, whatever is written while the pair is being shown.
- R8: Clock select code 3'b101 puts the half-rate clock on ck_pri. Every other code, including the default 3'b000, puts the full-rate clock there, whatever the data format.
- R9: Polarity 1 inverts both ck_pri and ck_half.
- R10: With polarity 0, ck_half is high in slots 1 and 3 and low in slots 0 and 2. Its rising edge therefore starts each luma sample of the narrow layout, and it toggles on every clock except when a pair restart forces slot 0.
- R11: When cfg_we is high, cfg_wdata is written to the field picked by cfg_addr: 0 = format [3:0], 1 = swap (bit 0), 2 = clock select (bits 2:0), 3 = polarity (bit 0). The new value is used from the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Full-rate sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration field select |
| cfg_wdata | input | 4 | Configuration write value |
| in_smp | input | 8 | Incoming 4:2:2 sample |
| in_sol | input | 1 | Marks the first sample (Cb) of a line |
| in_act | input | 1 | Incoming sample is active video |
| p_data | output | 16 | Pixel port data |
| p_oe | output | 16 | Per-bit drive enable for p_data |
| ck_pri | output | 1 | Primary output clock (full or half rate) |
| ck_half | output | 1 | Half-rate output clock |

## Verification
When the fourth sample of a pair is taken at clock edge k, slot 0 of that pair is visible right after edge k. Slots 1, 2 and 3 follow after edges k+1 to k+3. A configuration write sampled at edge m is first used by a pair that completes at edge m+1 or later. The bench applies stimulus on falling edges and numbers every sample from the line start. For each falling edge it works out which pair and which slot the previous rising edge exposed, and which format and swap were latched at that pair's completing edge, then compares at that falling edge. Clock outputs are compared at the same points: the full-rate clock is low there, so ck_pri on the full-rate setting equals the polarity bit.

// File: rtl/ppf_pkg.sv
package ppf_pkg;

  localparam int unsigned PX_W   = 8;
  localparam int unsigned BUS_W  = 2 * PX_W;
  localparam int unsigned FMT_W  = 4;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned CFG_AW = 2;
  localparam int unsigned CFG_DW = FMT_W;
  localparam int unsigned SLOT_W = 2;

  localparam logic [FMT_W-1:0] FMT_NARROW = 4'b0011;
  localparam logic [FMT_W-1:0] FMT_WIDE   = 4'b0010;
  localparam logic [SEL_W-1:0] SEL_HALF   = 3'b101;
  localparam logic [SEL_W-1:0] SEL_FULL   = 3'b000;

  localparam logic [CFG_AW-1:0] ADDR_FMT  = 2'd0;
  localparam logic [CFG_AW-1:0] ADDR_SWAP = 2'd1;
  localparam logic [CFG_AW-1:0] ADDR_SEL  = 2'd2;
  localparam logic [CFG_AW-1:0] ADDR_POL  = 2'd3;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_NARROW = 2'd1,
    MODE_WIDE   = 2'd2
  } mode_e;

  typedef struct packed {
    logic [PX_W-1:0] c_lead;
    logic [PX_W-1:0] y_even;
    logic [PX_W-1:0] c_trail;
    logic [PX_W-1:0] y_odd;
  } pair_t;

  function automatic mode_e decode_fmt(input logic [FMT_W-1:0] code);
    mode_e m;
    case (code)
      FMT_NARROW: m = MODE_NARROW;
      FMT_WIDE:   m = MODE_WIDE;
      default:    m = MODE_OFF;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/ppf_cfg_regs.sv
module ppf_cfg_regs
  import ppf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CFG_AW-1:0] addr,
  input  logic [CFG_DW-1:0] wdata,
  output logic [FMT_W-1:0]  fmt,
  output logic              swap,
  output logic [SEL_W-1:0]  sel,
  output logic              pol
);

  logic [FMT_W-1:0] fmt_q, fmt_d;
  logic             swap_q, swap_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             pol_q, pol_d;
  logic             en_fmt, en_swap, en_sel, en_pol;

  always_comb begin
    en_fmt  = we && (addr == ADDR_FMT);
    en_swap = we && (addr == ADDR_SWAP);
    en_sel  = we && (addr == ADDR_SEL);
    en_pol  = we && (addr == ADDR_POL);
    fmt_d   = en_fmt  ? wdata[FMT_W-1:0] : fmt_q;
    swap_d  = en_swap ? wdata[0]         : swap_q;
    sel_d   = en_sel  ? wdata[SEL_W-1:0] : sel_q;
    pol_d   = en_pol  ? wdata[0]         : pol_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q  <= FMT_NARROW;
      swap_q <= 1'b0;
      sel_q  <= SEL_FULL;
      pol_q  <= 1'b0;
    end else begin
      fmt_q  <= fmt_d;
      swap_q <= swap_d;
      sel_q  <= sel_d;
      pol_q  <= pol_d;
    end
  end

  assign fmt  = fmt_q;
  assign swap = swap_q;
  assign sel  = sel_q;
  assign pol  = pol_q;

endmodule

// File: rtl/ppf_pair_capture.sv
module ppf_pair_capture
  import ppf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PX_W-1:0]   in_smp,
  input  logic              in_sol,
  input  logic              in_act,
  input  logic [FMT_W-1:0]  fmt_cfg,
  input  logic              swap_cfg,
  output pair_t             pair,
  output mode_e             mode,
  output logic [SLOT_W-1:0] slot,
  output logic [SLOT_W-1:0] phase
);

  localparam int unsigned HOLD_N = 3;

  logic [SLOT_W-1:0] cnt_q, cnt_d;
  logic [SLOT_W-1:0] idx;
  logic              last;
  logic [PX_W-1:0]   hold_q [HOLD_N];
  logic [PX_W-1:0]   hold_d [HOLD_N];
  pair_t             pair_q, pair_d;
  mode_e             mode_q, mode_d;
  logic [SLOT_W-1:0] slot_q, slot_d;

  // chroma phase: a line start forces the Cb position
  always_comb begin
    idx   = in_sol ? '0 : cnt_q;
    last  = in_act && (idx == SLOT_W'(HOLD_N));
    cnt_d = in_act ? SLOT_W'(idx + 1'b1) : '0;
  end

  for (genvar i = 0; i < HOLD_N; i++) begin : g_hold
    always_comb begin
      hold_d[i] = (in_act && (idx == SLOT_W'(i))) ? in_smp : hold_q[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_q[i] <= '0;
      else        hold_q[i] <= hold_d[i];
    end
  end

  always_comb begin
    pair_d = pair_q;
    mode_d = mode_q;
    slot_d = SLOT_W'(slot_q + 1'b1);
    if (last) begin
      pair_d.c_lead  = swap_cfg ? hold_q[2] : hold_q[0];
      pair_d.y_even  = hold_q[1];
      pair_d.c_trail = swap_cfg ? hold_q[0] : hold_q[2];
      pair_d.y_odd   = in_smp;
      mode_d         = decode_fmt(fmt_cfg);
      slot_d         = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pair_q <= '0;
      mode_q <= MODE_NARROW;
      slot_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      pair_q <= pair_d;
      mode_q <= mode_d;
      slot_q <= slot_d;
    end
  end

  assign pair  = pair_q;
  assign mode  = mode_q;
  assign slot  = slot_q;
  assign phase = cnt_q;

endmodule

// File: rtl/ppf_lane_mux.sv
module ppf_lane_mux
  import ppf_pkg::*;
#(
  parameter bit NARROW_HI = 1'b1
)(
  input  pair_t             pair,
  input  mode_e             mode,
  input  logic [SLOT_W-1:0] slot,
  output logic [BUS_W-1:0]  bus,
  output logic [BUS_W-1:0]  oe
);

  logic [PX_W-1:0]  narrow_smp;
  logic [BUS_W-1:0] narrow_bus;
  logic [BUS_W-1:0] narrow_oe;
  logic [BUS_W-1:0] wide_bus;

  always_comb begin
    case (slot)
      2'd0:    narrow_smp = pair.c_lead;
      2'd1:    narrow_smp = pair.y_even;
      2'd2:    narrow_smp = pair.c_trail;
      default: narrow_smp = pair.y_odd;
    endcase
    wide_bus = slot[1] ? {pair.y_odd, pair.c_trail} : {pair.y_even, pair.c_lead};
  end

  if (NARROW_HI) begin : g_narrow_hi
    assign narrow_bus = {narrow_smp, {PX_W{1'b0}}};
    assign narrow_oe  = {{PX_W{1'b1}}, {PX_W{1'b0}}};
  end else begin : g_narrow_lo
    assign narrow_bus = {{PX_W{1'b0}}, narrow_smp};
    assign narrow_oe  = {{PX_W{1'b0}}, {PX_W{1'b1}}};
  end

  always_comb begin
    case (mode)
      MODE_NARROW: begin bus = narrow_bus; oe = narrow_oe; end
      MODE_WIDE:   begin bus = wide_bus;   oe = '1;        end
      default:     begin bus = '0;         oe = '0;        end
    endcase
  end

endmodule

// File: rtl/ppf_clk_out.sv
module ppf_clk_out
  import ppf_pkg::*;
(
  input  logic             clk,
  input  logic             div_q,
  input  logic             pol,
  input  logic [SEL_W-1:0] sel,
  output logic             ck_pri,
  output logic             ck_half
);

  logic ck_full;

  always_comb begin
    ck_full = clk ^ pol;
    ck_half = div_q ^ pol;
    ck_pri  = (sel == SEL_HALF) ? ck_half : ck_full;
  end

endmodule

// File: rtl/pixel_port_fmt.sv
module pixel_port_fmt
  import ppf_pkg::*;
#(
  parameter bit NARROW_HI = 1'b1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic [PX_W-1:0]   in_smp,
  input  logic              in_sol,
  input  logic              in_act,
  output logic [BUS_W-1:0]  p_data,
  output logic [BUS_W-1:0]  p_oe,
  output logic              ck_pri,
  output logic              ck_half
);

  logic [1:0]        rst_sync_q;
  logic              rst_n_sync;
  logic [FMT_W-1:0]  fmt_w;
  logic              swap_w;
  logic [SEL_W-1:0]  sel_w;
  logic              pol_w;
  pair_t             pair_w;
  mode_e             mode_w;
  logic [SLOT_W-1:0] slot_w;
  logic [SLOT_W-1:0] cnt_w;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_sync = rst_sync_q[1];

  ppf_cfg_regs u_cfg (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .fmt   (fmt_w),
    .swap  (swap_w),
    .sel   (sel_w),
    .pol   (pol_w)
  );

  ppf_pair_capture u_cap (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .in_smp   (in_smp),
    .in_sol   (in_sol),
    .in_act   (in_act),
    .fmt_cfg  (fmt_w),
    .swap_cfg (swap_w),
    .pair     (pair_w),
    .mode     (mode_w),
    .slot     (slot_w),
    .phase    (cnt_w)
  );

  ppf_lane_mux #(.NARROW_HI(NARROW_HI)) u_mux (
    .pair (pair_w),
    .mode (mode_w),
    .slot (slot_w),
    .bus  (p_data),
    .oe   (p_oe)
  );

  ppf_clk_out u_clk (
    .clk     (clk),
    .div_q   (slot_w[0]),
    .pol     (pol_w),
    .sel     (sel_w),
    .ck_pri  (ck_pri),
    .ck_half (ck_half)
  );

endmodule

// File: rtl/ppf_checker.sv
module ppf_checker
  import ppf_pkg::*;
#(
  parameter bit NARROW_HI = 1'b1
)(
  input logic              clk,
  input logic              rst_n,
  input logic              in_act,
  input logic              in_sol,
  input logic [SLOT_W-1:0] cnt,
  input logic [SLOT_W-1:0] slot,
  input logic              pol,
  input logic [BUS_W-1:0]  p_data,
  input logic [BUS_W-1:0]  p_oe,
  input logic              ck_half
);

  localparam logic [BUS_W-1:0] NMASK = NARROW_HI ?
    {{PX_W{1'b1}}, {PX_W{1'b0}}} : {{PX_W{1'b0}}, {PX_W{1'b1}}};

  assert_sol_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_act && in_sol) |=> (cnt == 2'd1));

  assert_lane_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (p_oe == '0) || (p_oe == NMASK) || (p_oe == '1));

  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (p_oe == '0) |-> (p_data == '0));

  assert_narrow_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (p_oe == NMASK) |-> ((p_data & ~NMASK) == '0));

  assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot != '0) |-> $stable(p_oe));

  assert_half_toggle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(pol) && (slot != '0)) |-> (ck_half != $past(ck_half)));

endmodule

bind pixel_port_fmt ppf_checker #(.NARROW_HI(NARROW_HI)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n_sync),
  .in_act  (in_act),
  .in_sol  (in_sol),
  .cnt     (cnt_w),
  .slot    (slot_w),
  .pol     (pol_w),
  .p_data  (p_data),
  .p_oe    (p_oe),
  .ck_half (ck_half)
);

// File: tb/pixel_port_fmt_tb.sv
`timescale 1ns/1ps
module pixel_port_fmt_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [3:0]  cfg_wdata;
  logic [7:0]  in_smp;
  logic        in_sol;
  logic        in_act;
  logic [15:0] p_data;
  logic [15:0] p_oe;
  logic        ck_pri;
  logic        ck_half;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // bench shadows of the configuration fields and of the latched pair settings
  logic [3:0] sh_fmt, act_fmt;
  logic       sh_swap, act_swap;
  logic [2:0] sh_sel;
  logic       sh_pol;

  always #4 clk = ~clk;

  pixel_port_fmt u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_smp(in_smp), .in_sol(in_sol), .in_act(in_act),
    .p_data(p_data), .p_oe(p_oe), .ck_pri(ck_pri), .ck_half(ck_half)
  );

  function automatic logic [7:0] smp(input int seed, input int k);
    return 8'(seed * 53 + k * 29 + 17);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shadow_wr(input logic [1:0] a, input logic [3:0] d);
    case (a)
      2'd0: sh_fmt  = d;
      2'd1: sh_swap = d[0];
      2'd2: sh_sel  = d[2:0];
      default: sh_pol = d[0];
    endcase
  endtask

  // R11: field writes through the configuration port
  task automatic cfg_write(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    shadow_wr(a, d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic check_slot(input string ph, input int seed, input int p, input int s);
    logic [7:0]  cb, y0, cr, y1, lead, trail, nsmp;
    logic [15:0] eb, eo;
    logic        half_e;
    string       req, creq;
    cb = smp(seed, 4*p);     y0 = smp(seed, 4*p + 1);
    cr = smp(seed, 4*p + 2); y1 = smp(seed, 4*p + 3);
    lead  = act_swap ? cr : cb;
    trail = act_swap ? cb : cr;
    case (s)
      0: nsmp = lead;
      1: nsmp = y0;
      2: nsmp = trail;
      default: nsmp = y1;
    endcase
    case (act_fmt)
      4'b0011: begin eo = 16'hFF00; eb = {nsmp, 8'h00}; req = "R2"; end
      4'b0010: begin eo = 16'hFFFF; eb = (s >= 2) ? {y1, trail} : {y0, lead}; req = "R3"; end
      default: begin eo = 16'h0000; eb = 16'h0000; req = "R4"; end
    endcase
    if (act_swap && (act_fmt == 4'b0011 || act_fmt == 4'b0010)) req = "R5";
    chk({ph, req, " data"}, {16'h0, p_data}, {16'h0, eb});
    chk({ph, req, " oe"},   {16'h0, p_oe},   {16'h0, eo});
    half_e = ((s % 2) == 1) ^ sh_pol;
    creq = sh_pol ? "R9" : ((sh_sel == 3'b101) ? "R8" : "R10");
    chk({ph, creq, " ck_half"}, {31'h0, ck_half}, {31'h0, half_e});
    // full-rate clock is low at the falling edge, so it reads as the polarity bit
    chk({ph, creq, " ck_pri"}, {31'h0, ck_pri},
        {31'h0, (sh_sel == 3'b101) ? half_e : sh_pol});
  endtask

  task automatic run_line(input string ph, input int np, input int seed,
                          input int wk, input logic [1:0] wa, input logic [3:0] wd);
    int n;
    n = 4 * np;
    for (int e = 0; e <= n + 3; e++) begin
      @(negedge clk);
      if (e >= 4) check_slot(ph, seed, (e - 4) / 4, (e - 4) % 4);
      cfg_we = 1'b0;
      if ((e % 4 == 3) && (e < n)) begin
        act_fmt  = sh_fmt;
        act_swap = sh_swap;
      end
      if (e == wk) begin
        cfg_we = 1'b1; cfg_addr = wa; cfg_wdata = wd;
        shadow_wr(wa, wd);
      end
      if (e < n) begin
        in_act = 1'b1; in_sol = (e == 0); in_smp = smp(seed, e);
      end else begin
        in_act = 1'b0; in_sol = 1'b0; in_smp = 8'h00;
      end
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = 2'd0; cfg_wdata = 4'd0;
    in_smp = 8'd0; in_sol = 1'b0; in_act = 1'b0;
    sh_fmt = 4'b0011; sh_swap = 1'b0; sh_sel = 3'b000; sh_pol = 1'b0;
    act_fmt = 4'b0011; act_swap = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state at the ports
    chk("R1 oe",     {16'h0, p_oe},   32'h0000FF00);
    chk("R1 data",   {16'h0, p_data}, 32'h0);
    chk("R1 ck_pri", {31'h0, ck_pri}, 32'h0);

    // R1: default configuration carries a line in the narrow layout
    run_line("R1 ", 3, 1, -1, 2'd0, 4'd0);

    // R11 with R2..R5: every format code with both chroma orders
    for (int f = 0; f < 16; f++) begin
      for (int sw = 0; sw < 2; sw++) begin
        cfg_write(2'd0, 4'(f));
        cfg_write(2'd1, 4'(sw));
        run_line("R11 ", 2, f * 2 + sw + 3, -1, 2'd0, 4'd0);
      end
    end

    // R8, R9, R10: every clock select code with both polarities
    cfg_write(2'd0, 4'b0010);
    cfg_write(2'd1, 4'd0);
    for (int sel = 0; sel < 8; sel++) begin
      for (int pl = 0; pl < 2; pl++) begin
        cfg_write(2'd2, 4'(sel));
        cfg_write(2'd3, 4'(pl));
        run_line("R11 ", 1, 40 + sel * 2 + pl, -1, 2'd0, 4'd0);
      end
    end
    cfg_write(2'd2, 4'd0);
    cfg_write(2'd3, 4'd0);

    // R7: settings written mid-pair take effect only at the next pair
    cfg_write(2'd0, 4'b0011);
    run_line("R7 ", 3, 60, 5, 2'd0, 4'b0010);
    run_line("R7 ", 3, 61, 3, 2'd1, 4'd1);
    run_line("R7 ", 3, 62, 9, 2'd0, 4'b0111);

    // R6: a line start drops a partial pair (two and three samples)
    cfg_write(2'd0, 4'b0011);
    cfg_write(2'd1, 4'd0);
    for (int part = 2; part <= 3; part++) begin
      for (int j = 0; j < part; j++) begin
        @(negedge clk);
        in_act = 1'b1; in_sol = (j == 0); in_smp = 8'(8'hA0 + j);
      end
      run_line("R6 ", 2, 70 + part, -1, 2'd0, 4'd0);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule